// File: doc/BRIEF.md
# Interrupt Message Queue with End-of-Interrupt

This block gathers interrupt events from two sources, input-change events and overcurrent events. Each event carries a per-channel flag vector. The block stores the events in a short first-in first-out pipeline. The oldest stored message is the current one: the host reads it from a status readback, and an active-low interrupt line stays asserted while any message is stored.

The host retires the current message by writing to a command register. The retire bit clears itself, so each qualifying write retires exactly one message, and the next stored message moves up at once. The interrupt line is not released after each acknowledge. It is released only by the retire that leaves the pipeline empty. When the pipeline is full, a new event is folded into the newest stored message, so no channel flag is lost.

Top module: `irq_msg_queue`

## Requirements
- R1: While reset is held and on its release, `irq_n` is 1 and both `stat_kind` and `stat_flags` are 0.
- R2: An event that reaches an empty queue is shown after the next rising clock edge. `stat_kind` shows 0 for an input-change event and 1 for an overcurrent event, `stat_flags` shows the event's flag vector, and `irq_n` goes to 0.
- R3: Messages are presented oldest first, and up to DEPTH (default 4) messages are held as separate entries.
- R4: When both sources strobe in the same cycle, the input-change message is queued ahead of the overcurrent message.
- R5: A write with `wr_addr` equal to 13 and `wr_data` bit 7 set retires the current message. At the next rising edge, the following stored message becomes current.
- R6: A write to address 13 with bit 7 clear, or a write to any other address, leaves the queue, the status and `irq_n` unchanged.
- R7: The retire command clears itself. One write retires one message, and cycles without a qualifying write retire nothing.
- R8: `irq_n` stays 0 across retires while messages remain. It returns to 1 only after the retire that removes the last message.
- R9: When the queue is full, the flags of a new event are ORed into the newest entry. That entry keeps its kind, and older entries are unchanged.
- R10: A retire command while the queue is empty has no effect.
- R11: A retire and events in the same cycle are applied retire first, so an event can take the slot that the retire frees.
- R12: Whenever the queue is empty, `stat_kind` and `stat_flags` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| chg_vld | input | 1 | Input-change event strobe |
| chg_flags | input | FLAG_W | Channels that changed |
| oc_vld | input | 1 | Overcurrent event strobe |
| oc_flags | input | FLAG_W | Channels in overcurrent |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| irq_n | output | 1 | Interrupt line, active low |
| stat_kind | output | 1 | Kind of the current message: 0 input change, 1 overcurrent |
| stat_flags | output | FLAG_W | Flags of the current message, 0 when empty |

## Verification
Every result is due exactly one rising edge after its stimulus. The queue registers update on that edge, and `irq_n`, `stat_kind` and `stat_flags` follow from the registers with no further delay. The bench therefore drives each stimulus on a falling edge, lets one rising edge pass, and then compares the outputs on the next falling edge. It compares them with a queue model that it updates at that same rising edge, applying a retire first and then the change event and the overcurrent event in that order.

// File: rtl/irq_q_pkg.sv
package irq_q_pkg;

   typedef enum logic {
      MSG_CHANGE  = 1'b0,
      MSG_OVERCUR = 1'b1
   } msg_kind_e;

   // Event sources, in the order they are queued within one cycle
   localparam int unsigned NUM_SRC = 2;
   localparam int unsigned SRC_CHG = 0;
   localparam int unsigned SRC_OC  = 1;

endpackage

// File: rtl/irq_eoi_decode.sv
module irq_eoi_decode #(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned EOI_ADDR = 13,
   parameter int unsigned EOI_BIT  = 7
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              retire
);

   localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(EOI_ADDR);

   // The command bit has no storage: it acts only in the cycle it is written.
   assign retire = wr_en && (wr_addr == CMD_ADDR) && wr_data[EOI_BIT];

endmodule

// File: rtl/irq_msg_fifo.sv
module irq_msg_fifo
   import irq_q_pkg::*;
#(
   parameter int unsigned FLAG_W = 8,
   parameter int unsigned DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              retire,
   input  logic              push_vld   [NUM_SRC],
   input  msg_kind_e         push_kind  [NUM_SRC],
   input  logic [FLAG_W-1:0] push_flags [NUM_SRC],
   output msg_kind_e         head_kind,
   output logic [FLAG_W-1:0] head_flags,
   output logic              occupied
);

   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   msg_kind_e         kind_q  [DEPTH];
   logic [FLAG_W-1:0] flags_q [DEPTH];
   msg_kind_e         kind_d  [DEPTH];
   logic [FLAG_W-1:0] flags_d [DEPTH];
   logic [CNT_W-1:0]  cnt_q, cnt_d;
   logic [DEPTH-1:0]  slot_live;

   // Occupancy map, one bit per slot
   for (genvar e = 0; e < DEPTH; e++) begin : g_live
      assign slot_live[e] = (cnt_q > CNT_W'(e));
   end

   // Next state: retire first, then the sources in index order
   always_comb begin
      int n;
      n = int'(cnt_q);
      for (int e = 0; e < DEPTH; e++) begin
         kind_d[e]  = kind_q[e];
         flags_d[e] = flags_q[e];
      end
      if (retire && n != 0) begin
         for (int e = 0; e < DEPTH - 1; e++) begin
            kind_d[e]  = kind_d[e+1];
            flags_d[e] = flags_d[e+1];
         end
         kind_d[DEPTH-1]  = MSG_CHANGE;
         flags_d[DEPTH-1] = '0;
         n = n - 1;
      end
      for (int s = 0; s < NUM_SRC; s++) begin
         if (push_vld[s]) begin
            if (n < DEPTH) begin
               for (int e = 0; e < DEPTH; e++) begin
                  if (e == n) begin
                     kind_d[e]  = push_kind[s];
                     flags_d[e] = push_flags[s];
                  end
               end
               n = n + 1;
            end else begin
               flags_d[DEPTH-1] = flags_d[DEPTH-1] | push_flags[s];
            end
         end
      end
      cnt_d = CNT_W'(n);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int e = 0; e < DEPTH; e++) begin
            kind_q[e]  <= MSG_CHANGE;
            flags_q[e] <= '0;
         end
      end else begin
         cnt_q <= cnt_d;
         for (int e = 0; e < DEPTH; e++) begin
            kind_q[e]  <= kind_d[e];
            flags_q[e] <= flags_d[e];
         end
      end
   end

   assign occupied   = slot_live[0];
   assign head_kind  = slot_live[0] ? kind_q[0] : MSG_CHANGE;
   assign head_flags = slot_live[0] ? flags_q[0] : '0;

endmodule

// File: rtl/irq_msg_queue.sv
module irq_msg_queue
   import irq_q_pkg::*;
#(
   parameter int unsigned FLAG_W   = 8,
   parameter int unsigned DEPTH    = 4,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned EOI_ADDR = 13,
   parameter int unsigned EOI_BIT  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chg_vld,
   input  logic [FLAG_W-1:0] chg_flags,
   input  logic              oc_vld,
   input  logic [FLAG_W-1:0] oc_flags,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              irq_n,
   output logic              stat_kind,
   output logic [FLAG_W-1:0] stat_flags
);

   // Elaboration-time parameter checks
   if (DEPTH < 2) begin : g_bad_depth
      $error("irq_msg_queue: DEPTH must be at least 2");
   end
   if (EOI_BIT >= DATA_W) begin : g_bad_bit
      $error("irq_msg_queue: EOI_BIT outside the data word");
   end
   if (EOI_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("irq_msg_queue: EOI_ADDR does not fit ADDR_W");
   end
   if (FLAG_W == 0) begin : g_bad_flags
      $error("irq_msg_queue: FLAG_W must be nonzero");
   end

   logic              retire;
   logic              src_vld   [NUM_SRC];
   msg_kind_e         src_kind  [NUM_SRC];
   logic [FLAG_W-1:0] src_flags [NUM_SRC];
   msg_kind_e         head_kind;
   logic              occupied;

   assign src_vld[SRC_CHG]   = chg_vld;
   assign src_kind[SRC_CHG]  = MSG_CHANGE;
   assign src_flags[SRC_CHG] = chg_flags;
   assign src_vld[SRC_OC]    = oc_vld;
   assign src_kind[SRC_OC]   = MSG_OVERCUR;
   assign src_flags[SRC_OC]  = oc_flags;

   irq_eoi_decode #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .EOI_ADDR(EOI_ADDR),
      .EOI_BIT (EOI_BIT)
   ) u_eoi (
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .retire (retire)
   );

   irq_msg_fifo #(
      .FLAG_W(FLAG_W),
      .DEPTH (DEPTH)
   ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .retire    (retire),
      .push_vld  (src_vld),
      .push_kind (src_kind),
      .push_flags(src_flags),
      .head_kind (head_kind),
      .head_flags(stat_flags),
      .occupied  (occupied)
   );

   assign stat_kind = (head_kind == MSG_OVERCUR);
   assign irq_n     = !occupied;

endmodule

// File: rtl/irq_msg_queue_chk.sv
module irq_msg_queue_chk #(
   parameter int unsigned FLAG_W   = 8,
   parameter int unsigned DEPTH    = 4,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned EOI_ADDR = 13,
   parameter int unsigned EOI_BIT  = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              chg_vld,
   input logic [FLAG_W-1:0] chg_flags,
   input logic              oc_vld,
   input logic [FLAG_W-1:0] oc_flags,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              irq_n,
   input logic              stat_kind,
   input logic [FLAG_W-1:0] stat_flags
);

   logic cmd_hit, any_evt;
   assign cmd_hit = wr_en && (wr_addr == ADDR_W'(EOI_ADDR)) && wr_data[EOI_BIT];
   assign any_evt = chg_vld || oc_vld;

   assert_empty_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      irq_n |-> (stat_kind == 1'b0 && stat_flags == '0));

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_hit && !any_evt) |=> ($stable(irq_n) && $stable(stat_kind) && $stable(stat_flags)));

   assert_ignored_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[EOI_BIT] && !any_evt) |=> ($stable(irq_n) && $stable(stat_flags)));

   assert_release_on_retire_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_n) |-> $past(cmd_hit));

   assert_raise_on_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_n) |-> $past(any_evt));

   assert_first_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_n && chg_vld && !oc_vld) |=> (!irq_n && !stat_kind && stat_flags == $past(chg_flags)));

endmodule

bind irq_msg_queue irq_msg_queue_chk #(
   .FLAG_W  (FLAG_W),
   .DEPTH   (DEPTH),
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .EOI_ADDR(EOI_ADDR),
   .EOI_BIT (EOI_BIT)
) u_chk (.*);

// File: tb/tb_irq_msg_queue.sv
`timescale 1ns/1ps
module tb_irq_msg_queue;

   localparam int FW = 8;
   localparam int DP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          chg_vld = 1'b0, oc_vld = 1'b0, wr_en = 1'b0;
   logic [FW-1:0] chg_flags = '0, oc_flags = '0;
   logic [3:0]    wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic          irq_n, stat_kind;
   logic [FW-1:0] stat_flags;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   logic          m_kind  [DP];
   logic [FW-1:0] m_flags [DP];
   int            m_cnt = 0;

   always #4 clk = ~clk;

   irq_msg_queue dut (
      .clk(clk), .rst_n(rst_n),
      .chg_vld(chg_vld), .chg_flags(chg_flags),
      .oc_vld(oc_vld), .oc_flags(oc_flags),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .irq_n(irq_n), .stat_kind(stat_kind), .stat_flags(stat_flags)
   );

   // Expected queue behaviour: retire first (R11), change before overcurrent (R4),
   // OR-merge into the newest entry when full (R9)
   task automatic model_push(input logic k, input logic [FW-1:0] f);
      if (m_cnt < DP) begin
         m_kind[m_cnt] = k; m_flags[m_cnt] = f; m_cnt++;
      end else begin
         m_flags[DP-1] = m_flags[DP-1] | f;
      end
   endtask

   task automatic model_apply(input logic cv, input logic [FW-1:0] cf, input logic ov,
                              input logic [FW-1:0] of, input logic we,
                              input logic [3:0] wa, input logic [7:0] wd);
      if (we && wa == 4'd13 && wd[7] && m_cnt != 0) begin
         for (int e = 0; e < DP - 1; e++) begin
            m_kind[e] = m_kind[e+1]; m_flags[e] = m_flags[e+1];
         end
         m_cnt--;
      end
      if (cv) model_push(1'b0, cf);
      if (ov) model_push(1'b1, of);
   endtask

   task automatic check(input string tag);
      logic          e_irq, e_kind;
      logic [FW-1:0] e_flags;
      e_irq   = (m_cnt == 0);
      e_kind  = (m_cnt == 0) ? 1'b0 : m_kind[0];
      e_flags = (m_cnt == 0) ? '0 : m_flags[0];
      checks++;
      if (irq_n !== e_irq || stat_kind !== e_kind || stat_flags !== e_flags) begin
         failures++;
         $display("FAIL %s: got irq_n=%0b kind=%0b flags=%h, expected irq_n=%0b kind=%0b flags=%h",
                  tag, irq_n, stat_kind, stat_flags, e_irq, e_kind, e_flags);
      end
   endtask

   task automatic step(input string tag, input logic cv, input logic [FW-1:0] cf,
                       input logic ov, input logic [FW-1:0] of, input logic we,
                       input logic [3:0] wa, input logic [7:0] wd);
      chg_vld = cv; chg_flags = cf; oc_vld = ov; oc_flags = of;
      wr_en = we; wr_addr = wa; wr_data = wd;
      @(posedge clk);
      model_apply(cv, cf, ov, of, we, wa, wd);
      @(negedge clk);
      chg_vld = 1'b0; oc_vld = 1'b0; wr_en = 1'b0;
      check(tag);
   endtask

   task automatic retire_cmd(input string tag);
      step(tag, 1'b0, '0, 1'b0, '0, 1'b1, 4'd13, 8'h80);
   endtask

   initial begin
      void'($urandom(32'h1d5e_a11c));
      for (int e = 0; e < DP; e++) begin m_kind[e] = 1'b0; m_flags[e] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset held");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release");

      step("R2 change into empty", 1'b1, 8'h5A, 1'b0, '0, 1'b0, '0, '0);
      step("R6 bit7 clear", 1'b0, '0, 1'b0, '0, 1'b1, 4'd13, 8'h7F);
      step("R6 other address", 1'b0, '0, 1'b0, '0, 1'b1, 4'd12, 8'hFF);
      retire_cmd("R5 R8 retire last");
      retire_cmd("R10 retire on empty");
      step("R2 overcurrent into empty", 1'b0, '0, 1'b1, 8'h81, 1'b0, '0, '0);
      retire_cmd("R5 drain");
      step("R4 both same cycle", 1'b1, 8'h0F, 1'b1, 8'hF0, 1'b0, '0, '0);
      step("R7 idle after", 1'b0, '0, 1'b0, '0, 1'b0, '0, '0);
      retire_cmd("R4 R8 second is overcurrent");
      retire_cmd("R8 release when empty");

      step("R3 fill a", 1'b1, 8'h01, 1'b0, '0, 1'b0, '0, '0);
      step("R3 fill b", 1'b0, '0, 1'b1, 8'h02, 1'b0, '0, '0);
      step("R3 fill cd", 1'b1, 8'h04, 1'b1, 8'h08, 1'b0, '0, '0);
      step("R9 merge full", 1'b1, 8'h30, 1'b0, '0, 1'b0, '0, '0);
      step("R9 merge both", 1'b1, 8'h40, 1'b1, 8'h80, 1'b0, '0, '0);
      step("R11 retire and push full", 1'b1, 8'hAA, 1'b0, '0, 1'b1, 4'd13, 8'h80);
      for (int i = 0; i < DP; i++) retire_cmd("R3 R8 ordered drain");
      retire_cmd("R10 empty again");

      for (int i = 0; i < 3000; i++) begin
         logic          cv, ov, we;
         logic [FW-1:0] cf, of;
         logic [3:0]    wa;
         logic [7:0]    wd;
         cv = ($urandom % 4) == 0;
         ov = ($urandom % 5) == 0;
         cf = FW'($urandom);
         of = FW'($urandom);
         we = ($urandom % 3) == 0;
         wa = (($urandom % 4) == 0) ? 4'($urandom) : 4'd13;
         wd = 8'($urandom);
         step("R3 R5 R9 random", cv, cf, ov, of, we, wa, wd);
      end

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule